// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block passes data between two parallel ports, A and B. The ports are split into independent halves, and each half has two separate sets of storage: one for traffic from A to B and one for traffic from B to A. Each direction of each half has three active-low controls: a chip select, a load control and a drive control. The chip select gates both the loading of the storage and the driving of the far port. While the load control is low, each clock edge loads the storage from the near port. While it is high, the storage keeps the value it loaded at the last edge where the load control was low. The far port is driven from the storage only when both the chip select and the drive control are low.

The design has no internal tri-state. Each port is presented as an input bus, an output bus and a drive-enable bit for each half, and the surrounding logic resolves these into the shared wires. The parameter `BUS_HOLD` enables a bus-hold option. With it, each port has an input-valid qualifier for each half. While the qualifier is low, the storage loads the last value that was seen while it was high, so a floating port does not corrupt the data. A clash flag for each half shows when both directions of that half drive at the same time.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: Each half (bits h*HALF_W up to h*HALF_W+HALF_W-1) responds only to its own controls. Controls of one half never change the storage, the outputs or the drive bits of another half.
- R2: While the A-to-B chip select of a half is high, that half's A-to-B storage keeps its value, `b_drv` is 0, and the half's bits of `b_out` are 0, whatever the load and drive controls are.
- R3: When the A-to-B chip select and load control of a half are both low at a rising clock edge, the half's A-to-B storage takes the A source value. The storage is visible on `b_out` once the drive conditions hold.
- R4: While the A-to-B load control of a half is high, its storage keeps the value captured at the last edge where the load control was low.
- R5: `b_drv[h]` is 1 in the same cycle exactly when the A-to-B chip select and drive control of half h are both low, outside reset. While it is 1, the half of `b_out` equals the A-to-B storage; otherwise that half of `b_out` is 0.
- R6: B-to-A transfer behaves as in R2 to R5, using its own chip select, load and drive controls, its own storage, `a_out` and `a_drv`. It never alters the A-to-B storage.
- R7: With bus hold enabled, while a port's valid bit for a half is low, the source value for that half is the last port value sampled while the valid bit was high. The hold value is 0 after reset.
- R8: `clash[h]` is 1 exactly when `a_drv[h]` and `b_drv[h]` are both 1. Each drive bit still follows its own controls.
- R9: While `rst_n` is low, all drive bits, data outputs and clash bits are 0. Reset clears the storage and the hold values to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also forces drives off |
| a_in | input | HALF_W*HALVES | Value seen on port A |
| a_in_vld | input | HALVES | Port A actively driven, per half (bus hold) |
| b_in | input | HALF_W*HALVES | Value seen on port B |
| b_in_vld | input | HALVES | Port B actively driven, per half (bus hold) |
| ab_cs_n | input | HALVES | A-to-B chip select, active low |
| ab_ld_n | input | HALVES | A-to-B load control, active low |
| ab_oe_n | input | HALVES | A-to-B drive control, active low |
| ba_cs_n | input | HALVES | B-to-A chip select, active low |
| ba_ld_n | input | HALVES | B-to-A load control, active low |
| ba_oe_n | input | HALVES | B-to-A drive control, active low |
| b_out | output | HALF_W*HALVES | Value to drive onto port B |
| b_drv | output | HALVES | Port B drive enable per half |
| a_out | output | HALF_W*HALVES | Value to drive onto port A |
| a_drv | output | HALVES | Port A drive enable per half |
| clash | output | HALVES | Both directions of a half driving at once |

## Verification
The bench first checks that a deselected direction ignores new port data while its load control is low; a design that let the load control act alone would show the new value once it is reselected. It checks that raising the load control freezes the value of the previous edge, so a one-cycle capture error would show a later value. It floats one half of port A while the other stays valid, so a design that lost the hold value would load garbage into the floating half. It runs both directions of a half at once and random mixed controls, so a drive or clash bit that leaked into the other half or direction would differ from the reference model in that cycle.

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
  parameter int HALF_W   = 8,
  parameter int HALVES   = 2,
  parameter bit BUS_HOLD = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [HALF_W*HALVES-1:0] a_in,
  input  logic [HALVES-1:0]        a_in_vld,
  input  logic [HALF_W*HALVES-1:0] b_in,
  input  logic [HALVES-1:0]        b_in_vld,
  input  logic [HALVES-1:0]        ab_cs_n,
  input  logic [HALVES-1:0]        ab_ld_n,
  input  logic [HALVES-1:0]        ab_oe_n,
  input  logic [HALVES-1:0]        ba_cs_n,
  input  logic [HALVES-1:0]        ba_ld_n,
  input  logic [HALVES-1:0]        ba_oe_n,
  output logic [HALF_W*HALVES-1:0] b_out,
  output logic [HALVES-1:0]        b_drv,
  output logic [HALF_W*HALVES-1:0] a_out,
  output logic [HALVES-1:0]        a_drv,
  output logic [HALVES-1:0]        clash
);
  localparam int W = HALF_W * HALVES;

  logic [W-1:0] ab_q, ba_q;
  logic [W-1:0] a_src, b_src;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam int LO = h * HALF_W;

    if (BUS_HOLD) begin : g_hold
      logic [HALF_W-1:0] a_hold, b_hold;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          a_hold <= '0;
          b_hold <= '0;
        end else begin
          if (a_in_vld[h]) a_hold <= a_in[LO +: HALF_W];
          if (b_in_vld[h]) b_hold <= b_in[LO +: HALF_W];
        end
      end

      assign a_src[LO +: HALF_W] = a_in_vld[h] ? a_in[LO +: HALF_W] : a_hold;
      assign b_src[LO +: HALF_W] = b_in_vld[h] ? b_in[LO +: HALF_W] : b_hold;
    end else begin : g_nohold
      assign a_src[LO +: HALF_W] = a_in[LO +: HALF_W];
      assign b_src[LO +: HALF_W] = b_in[LO +: HALF_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ab_q[LO +: HALF_W] <= '0;
        ba_q[LO +: HALF_W] <= '0;
      end else begin
        if (!ab_cs_n[h] && !ab_ld_n[h]) ab_q[LO +: HALF_W] <= a_src[LO +: HALF_W];
        if (!ba_cs_n[h] && !ba_ld_n[h]) ba_q[LO +: HALF_W] <= b_src[LO +: HALF_W];
      end
    end

    assign b_drv[h] = rst_n & ~ab_cs_n[h] & ~ab_oe_n[h];
    assign a_drv[h] = rst_n & ~ba_cs_n[h] & ~ba_oe_n[h];
    assign b_out[LO +: HALF_W] = b_drv[h] ? ab_q[LO +: HALF_W] : '0;
    assign a_out[LO +: HALF_W] = a_drv[h] ? ba_q[LO +: HALF_W] : '0;
    assign clash[h] = a_drv[h] & b_drv[h];
  end
endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
module bidir_latch_xcvr_chk #(
  parameter int HALF_W = 8,
  parameter int HALVES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [HALF_W*HALVES-1:0] a_in,
  input logic [HALVES-1:0]        a_in_vld,
  input logic [HALF_W*HALVES-1:0] b_in,
  input logic [HALVES-1:0]        b_in_vld,
  input logic [HALVES-1:0]        ab_cs_n,
  input logic [HALVES-1:0]        ab_ld_n,
  input logic [HALVES-1:0]        ab_oe_n,
  input logic [HALVES-1:0]        ba_cs_n,
  input logic [HALVES-1:0]        ba_ld_n,
  input logic [HALVES-1:0]        ba_oe_n,
  input logic [HALF_W*HALVES-1:0] b_out,
  input logic [HALVES-1:0]        b_drv,
  input logic [HALF_W*HALVES-1:0] a_out,
  input logic [HALVES-1:0]        a_drv,
  input logic [HALVES-1:0]        clash,
  input logic [HALF_W*HALVES-1:0] ab_q,
  input logic [HALF_W*HALVES-1:0] ba_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (a_drv == '0 && b_drv == '0 && clash == '0 && a_out == '0 && b_out == '0); // R9
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    localparam int LO = h * HALF_W;

    AST_AB_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ab_cs_n[h] |=> $stable(ab_q[LO +: HALF_W])); // R2
    AST_AB_DRV_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      b_drv[h] |-> (!ab_cs_n[h] && !ab_oe_n[h])); // R2
    AST_AB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_cs_n[h] && !ab_ld_n[h] && a_in_vld[h]) |=> ab_q[LO +: HALF_W] == $past(a_in[LO +: HALF_W])); // R3
    AST_AB_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      ab_ld_n[h] |=> $stable(ab_q[LO +: HALF_W])); // R4
    AST_B_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      b_drv[h] |-> b_out[LO +: HALF_W] == ab_q[LO +: HALF_W]); // R5
    AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !b_drv[h] |-> b_out[LO +: HALF_W] == '0); // R5
    AST_BA_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ba_cs_n[h] |=> $stable(ba_q[LO +: HALF_W])); // R6
    AST_BA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_cs_n[h] && !ba_ld_n[h] && b_in_vld[h]) |=> ba_q[LO +: HALF_W] == $past(b_in[LO +: HALF_W])); // R6
    AST_A_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      a_drv[h] |-> a_out[LO +: HALF_W] == ba_q[LO +: HALF_W]); // R6
    AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !a_drv[h] |-> a_out[LO +: HALF_W] == '0); // R6
    AST_A_DRV_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      a_drv[h] |-> (!ba_cs_n[h] && !ba_oe_n[h])); // R6
    AST_CLASH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      clash[h] == (a_drv[h] && b_drv[h])); // R8
  end
endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (.*);

// File: tb/bidir_latch_xcvr_tb.sv
module bidir_latch_xcvr_tb;
  localparam int HW = 8;
  localparam int NH = 2;
  localparam int W  = HW * NH;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [W-1:0]  a_in, b_in;
  logic [NH-1:0] a_in_vld, b_in_vld;
  logic [NH-1:0] ab_cs_n, ab_ld_n, ab_oe_n, ba_cs_n, ba_ld_n, ba_oe_n;
  logic [W-1:0]  b_out, a_out;
  logic [NH-1:0] b_drv, a_drv, clash;

  bidir_latch_xcvr #(.HALF_W(HW), .HALVES(NH), .BUS_HOLD(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_in_vld(a_in_vld), .b_in(b_in), .b_in_vld(b_in_vld),
    .ab_cs_n(ab_cs_n), .ab_ld_n(ab_ld_n), .ab_oe_n(ab_oe_n),
    .ba_cs_n(ba_cs_n), .ba_ld_n(ba_ld_n), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv), .clash(clash)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R9";
  bit    done = 1'b0;

  // reference state: one stored word per direction, one hold word per port
  logic [W-1:0] m_ab, m_ba, m_ha, m_hb;

  always @(posedge clk) begin
    logic [HW-1:0] sa, sb;
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; m_ha <= '0; m_hb <= '0;
    end else begin
      for (int h = 0; h < NH; h++) begin
        sa = a_in_vld[h] ? a_in[h*HW +: HW] : m_ha[h*HW +: HW];
        sb = b_in_vld[h] ? b_in[h*HW +: HW] : m_hb[h*HW +: HW];
        if (a_in_vld[h]) m_ha[h*HW +: HW] <= a_in[h*HW +: HW];
        if (b_in_vld[h]) m_hb[h*HW +: HW] <= b_in[h*HW +: HW];
        if (!ab_cs_n[h] && !ab_ld_n[h]) m_ab[h*HW +: HW] <= sa;
        if (!ba_cs_n[h] && !ba_ld_n[h]) m_ba[h*HW +: HW] <= sb;
      end
    end
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [NH-1:0] eb, ea;
    logic [W-1:0]  ob, oa;
    for (int h = 0; h < NH; h++) begin
      eb[h] = rst_n && !ab_cs_n[h] && !ab_oe_n[h];
      ea[h] = rst_n && !ba_cs_n[h] && !ba_oe_n[h];
      ob[h*HW +: HW] = eb[h] ? m_ab[h*HW +: HW] : '0;
      oa[h*HW +: HW] = ea[h] ? m_ba[h*HW +: HW] : '0;
    end
    chk("b_drv", W'(b_drv), W'(eb));
    chk("a_drv", W'(a_drv), W'(ea));
    chk("b_out", b_out, ob);
    chk("a_out", a_out, oa);
    chk("clash", W'(clash), W'(ea & eb));
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in phase %s", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    // R9: controls asking for drive while in reset
    rst_n = 1'b0; a_in = 16'hA5C3; b_in = 16'h3C5A; a_in_vld = '1; b_in_vld = '1;
    ab_cs_n = '0; ab_ld_n = '0; ab_oe_n = '0;
    ba_cs_n = '0; ba_ld_n = '0; ba_oe_n = '0;
    cyc(3);
    ab_ld_n = '1; ba_ld_n = '1; ba_oe_n = '1;
    rst_n = 1'b1;
    cyc(2);               // storage cleared: drive shows zeros

    cur_req = "R3";       // transparent loading
    ab_ld_n = '0; a_in = 16'hA5C3;
    cyc(2);
    a_in = 16'h1234;
    cyc(2);

    cur_req = "R4";       // storage holds while load control is high
    ab_ld_n = '1; a_in = 16'hFFFF;
    cyc(3);

    cur_req = "R2";       // deselected: no load, no drive
    ab_cs_n = '1; ab_ld_n = '0; a_in = 16'h0F0F;
    cyc(2);
    ab_cs_n = '0; ab_ld_n = '1;
    cyc(2);               // expect 1234 back

    cur_req = "R5";
    ab_oe_n = 2'b01; cyc(2);
    ab_oe_n = 2'b10; cyc(2);
    ab_oe_n = 2'b00; cyc(1);

    cur_req = "R6";       // B-to-A with its own storage
    ab_oe_n = '1;
    b_in = 16'hBEEF; ba_ld_n = '0; ba_oe_n = '0;
    cyc(2);
    ba_ld_n = '1; b_in = 16'h0000;
    cyc(2);

    cur_req = "R8";       // both directions drive
    ab_oe_n = 2'b00; cyc(2);
    ba_oe_n = 2'b01; cyc(2);

    cur_req = "R7";       // floating port A: hold value 0F0F loaded
    a_in_vld = 2'b00; a_in = 16'hDEAD; ab_ld_n = '0;
    cyc(3);
    a_in_vld = 2'b01;     // low half live, high half still held
    cyc(2);
    a_in_vld = '1;

    cur_req = "R1";       // random mixed traffic across halves
    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      a_in_vld = NH'($urandom); b_in_vld = NH'($urandom);
      ab_cs_n = NH'($urandom); ab_ld_n = NH'($urandom); ab_oe_n = NH'($urandom);
      ba_cs_n = NH'($urandom); ba_ld_n = NH'($urandom); ba_oe_n = NH'($urandom);
      cyc(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule